// File: doc/BRIEF.md
# Serial FIFO Status Controller

This block sits between a two-wire serial interface's protocol engines and the processor bus. It holds four small byte queues: one for bytes the master side sends, one for bytes the master side receives, and a matching pair for the slave side. Each queue has its own push and pop strobe with byte data, so both the bus and the serial engines move bytes in and out without extra handshakes.

A single 16-bit status/control word reports the occupancy of all four queues. Each queue has a 2-bit code, and two request bits let software empty a queue. The status code tells a byte that was just stored apart from one that has settled. Emptying the master transmit queue also discards the slave receive queue.

The protocol engine itself is outside this block and appears only as push and pop strobes. Each queue also raises a sticky overflow flag when a byte is dropped.

Top module: `serial_fifo_status`

## Requirements
- R1: Queue index i (bits i of `push_i`/`pop_i`, byte lane [8i+7:8i] of `wdata_i`/`rdata_o`) reports its code in `stat_o[2i+1:2i]`. Index 0 is slave transmit, 1 is slave receive, 2 is master transmit and 3 is master receive.
- R2: The codes are: 2'b00 when a queue is empty, 2'b11 when it holds DEPTH bytes (two by default), and 2'b01 for exactly one clock after a push into an empty queue. The code is 2'b10 whenever the queue holds bytes, is not full and is not in that one-clock window. A second push during the window gives 2'b11 at once.
- R3: Bytes leave in the order they were pushed. A queue's `rdata_o` lane shows its oldest byte and shows 8'h00 while the queue is empty.
- R4: A push into a full queue is dropped and does not change its contents or code. It sets `ovf_o[i]`, which stays 1 until reset.
- R5: A pop from an empty queue leaves the code at 2'b00 and the lane at 8'h00, and the next pushed byte is stored normally.
- R6: Writing 1 to `stat_o` bit 8 through `reg_wr_i`/`reg_wdata_i` makes bit 8 read 1 on the next cycle. On the clock after that, queue 0 becomes empty and bit 8 returns to 0.
- R7: Bit 9 behaves like bit 8, but its clear empties both queue 2 and queue 1. Queues 0 and 3 are left untouched.
- R8: `stat_o[15:10]` always reads 0. Writing ones to bits 15:10 or 7:0 of `reg_wdata_i` changes nothing.
- R9: On the clock where a clear takes effect, a push or pop to the affected queue is ignored and the queue ends empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 4 | Push strobe per queue |
| wdata_i | input | 32 | Byte to push, one lane per queue |
| pop_i | input | 4 | Pop strobe per queue |
| rdata_o | output | 32 | Oldest byte per queue, 0 when empty |
| reg_wr_i | input | 1 | Write strobe for the status/control word |
| reg_wdata_i | input | 16 | Write data; only bits 9 and 8 act |
| stat_o | output | 16 | Status codes and pending clear requests |
| ovf_o | output | 4 | Sticky overflow flag per queue |

## Verification
The bench builds the block with DEPTH=2 and WIDTH=8. At that depth the full code and the overflow path are two and three pushes away, so every code transition can be checked cycle by cycle. This includes the one-clock just-written window and a push that lands inside it. The tests also cover a clear that coincides with a push, and the cross-queue clear, using known occupancies.

// File: rtl/sfs_pkg.sv
// Package sfs_pkg
// Shared constants and the status code type for the serial FIFO status block.
// Assumes a fixed 16-bit status word holding four 2-bit codes.
package sfs_pkg;
    localparam int NUM_Q    = 4;
    localparam int Q_STX    = 0;
    localparam int Q_SRX    = 1;
    localparam int Q_MTX    = 2;
    localparam int Q_MRX    = 3;
    localparam int CLR_STX  = 8;
    localparam int CLR_MTX  = 9;
    localparam int STAT_W   = 16;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_FRESH = 2'b01,
        ST_HELD  = 2'b10,
        ST_FULL  = 2'b11
    } qstat_e;
endpackage

// File: rtl/sfs_byte_fifo.sv
// Module sfs_byte_fifo
// One byte queue with a 2-bit occupancy code, a sticky overflow flag and a
// synchronous clear. The clear wins over push and pop on the same edge.
// Assumes pushes into a full queue and pops from an empty one may arrive.
module sfs_byte_fifo
    import sfs_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [WIDTH-1:0] rdata_o,
    output qstat_e           code_o,
    output logic             ovf_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             fresh;
    logic             full, empty, push_ok, pop_ok;

    // Decode occupancy and qualify the strobes.
    always_comb begin
        full    = (count == FULL_CNT);
        empty   = (count == '0);
        push_ok = push_i && !full && !flush_i;
        pop_ok  = pop_i && !empty && !flush_i;
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata_i;
        end
    end

    // Track pointers, occupancy, the just-written marker and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            fresh  <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            ovf_o <= ovf_o | (push_i && full && !flush_i);
            if (flush_i) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
                fresh  <= 1'b0;
            end else begin
                if (push_ok) begin
                    wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
                end
                if (pop_ok) begin
                    rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                end
                unique case ({push_ok, pop_ok})
                    2'b10:   count <= count + 1'b1;
                    2'b01:   count <= count - 1'b1;
                    default: count <= count;
                endcase
                fresh <= push_ok && empty;
            end
        end
    end

    // Form the status code and the head byte.
    always_comb begin
        if (empty)      code_o = ST_EMPTY;
        else if (full)  code_o = ST_FULL;
        else if (fresh) code_o = ST_FRESH;
        else            code_o = ST_HELD;
        rdata_o = empty ? '0 : mem[rd_ptr];
    end

    // R2: the just-written code lasts a single clock.
    a_r2_fresh_once: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o == ST_FRESH) |=> (code_o != ST_FRESH));

    // R4: a push into a full queue changes nothing and flags overflow.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i && !flush_i) |=> (count == $past(count) && ovf_o));

    // R4: the overflow flag is sticky.
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R5: a pop from an empty queue leaves it empty.
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_i && !push_i) |=> (code_o == ST_EMPTY && rdata_o == '0));

    // R9: a clear always leaves the queue empty.
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (code_o == ST_EMPTY));
endmodule

// File: rtl/sfs_clear_ctrl.sv
// Module sfs_clear_ctrl
// Holds the two self-clearing clear requests. A request written as 1 is
// pending for one cycle and drops on the edge where the clear is applied.
// Assumes a write that arrives while a request is pending is absorbed.
module sfs_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic req_stx_i,
    input  logic req_mtx_i,
    output logic pend_stx_o,
    output logic pend_mtx_o
);
    // Capture a request, then retire it on the following edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_stx_o <= 1'b0;
            pend_mtx_o <= 1'b0;
        end else begin
            pend_stx_o <= pend_stx_o ? 1'b0 : (wr_i && req_stx_i);
            pend_mtx_o <= pend_mtx_o ? 1'b0 : (wr_i && req_mtx_i);
        end
    end

    // R6: a pending request clears itself one clock later.
    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pend_stx_o |=> !pend_stx_o);

    // R6: an idle request set by a write reads back as pending.
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && req_stx_i && !pend_stx_o) |=> pend_stx_o);

    // R7: the master-transmit request also clears itself.
    a_r7_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pend_mtx_o |=> !pend_mtx_o);
endmodule

// File: rtl/serial_fifo_status.sv
// Module serial_fifo_status
// Four byte queues for a dual-role two-wire serial interface with a shared
// 16-bit status/control word. The master-transmit clear also empties the
// slave-receive queue. Assumes the strobes come from the bus and the engines
// already synchronised to clk.
module serial_fifo_status
    import sfs_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_Q-1:0]       push_i,
    input  logic [NUM_Q*WIDTH-1:0] wdata_i,
    input  logic [NUM_Q-1:0]       pop_i,
    output logic [NUM_Q*WIDTH-1:0] rdata_o,
    input  logic                   reg_wr_i,
    input  logic [STAT_W-1:0]      reg_wdata_i,
    output logic [STAT_W-1:0]      stat_o,
    output logic [NUM_Q-1:0]       ovf_o
);
    logic             pend_stx, pend_mtx;
    logic [NUM_Q-1:0] q_flush;
    qstat_e           q_code [NUM_Q];
    logic             unused_wdata_bits;

    assign unused_wdata_bits = ^{reg_wdata_i[STAT_W-1:CLR_MTX+1], reg_wdata_i[CLR_STX-1:0]};

    sfs_clear_ctrl u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .req_stx_i  (reg_wdata_i[CLR_STX]),
        .req_mtx_i  (reg_wdata_i[CLR_MTX]),
        .pend_stx_o (pend_stx),
        .pend_mtx_o (pend_mtx)
    );

    // Route each clear request to the queues it empties.
    always_comb begin
        q_flush        = '0;
        q_flush[Q_STX] = pend_stx;
        q_flush[Q_SRX] = pend_mtx;
        q_flush[Q_MTX] = pend_mtx;
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        sfs_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push_i[g]),
            .wdata_i (wdata_i[g*WIDTH +: WIDTH]),
            .pop_i   (pop_i[g]),
            .flush_i (q_flush[g]),
            .rdata_o (rdata_o[g*WIDTH +: WIDTH]),
            .code_o  (q_code[g]),
            .ovf_o   (ovf_o[g])
        );
    end

    // Assemble the status word; reserved bits read zero.
    always_comb begin
        stat_o = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            stat_o[2*i +: 2] = q_code[i];
        end
        stat_o[CLR_STX] = pend_stx;
        stat_o[CLR_MTX] = pend_mtx;
    end

    // R7: the master-transmit clear empties both master transmit and slave receive.
    a_r7_cross_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pend_mtx |=> (stat_o[2*Q_MTX +: 2] == 2'b00 && stat_o[2*Q_SRX +: 2] == 2'b00));
endmodule

// File: tb/sim_serial_fifo_status.sv
module sim_serial_fifo_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  push_i = '0;
    logic [31:0] wdata_i = '0;
    logic [3:0]  pop_i = '0;
    logic [31:0] rdata_o;
    logic        reg_wr_i = 1'b0;
    logic [15:0] reg_wdata_i = '0;
    logic [15:0] stat_o;
    logic [3:0]  ovf_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    serial_fifo_status #(.DEPTH(2), .WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .wdata_i(wdata_i),
        .pop_i(pop_i), .rdata_o(rdata_o), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .stat_o(stat_o), .ovf_o(ovf_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_push(int i, logic [7:0] d);
        push_i[i] = 1'b1;
        wdata_i[8*i +: 8] = d;
        cyc();
        push_i[i] = 1'b0;
    endtask

    task automatic do_pop(int i);
        pop_i[i] = 1'b1;
        cyc();
        pop_i[i] = 1'b0;
    endtask

    task automatic do_write(logic [15:0] v);
        reg_wr_i = 1'b1;
        reg_wdata_i = v;
        cyc();
        reg_wr_i = 1'b0;
        reg_wdata_i = '0;
    endtask

    function automatic logic [1:0] code(int i);
        return stat_o[2*i +: 2];
    endfunction

    task automatic t_reset();
        check("R2 reset status", 32'(stat_o), 32'h0);
        check("R3 reset rdata", rdata_o, 32'h0);
        check("R4 reset ovf", 32'(ovf_o), 32'h0);
    endtask

    task automatic t_codes_order();
        do_push(0, 8'hA1);
        check("R2 fresh code", 32'(code(0)), 32'h1);
        check("R3 head byte", 32'(rdata_o[7:0]), 32'hA1);
        cyc();
        check("R2 held code", 32'(code(0)), 32'h2);
        do_push(0, 8'hB2);
        check("R2 full code", 32'(code(0)), 32'h3);
        do_push(0, 8'hC3);
        check("R4 full push ignored", 32'(code(0)), 32'h3);
        check("R4 ovf set", 32'(ovf_o), 32'h1);
        check("R4 head kept", 32'(rdata_o[7:0]), 32'hA1);
        do_pop(0);
        check("R3 second byte", 32'(rdata_o[7:0]), 32'hB2);
        check("R2 held after pop", 32'(code(0)), 32'h2);
        do_pop(0);
        check("R2 empty after pops", 32'(code(0)), 32'h0);
        check("R3 empty rdata", 32'(rdata_o[7:0]), 32'h0);
    endtask

    task automatic t_empty_pop();
        do_pop(0);
        check("R5 empty pop code", 32'(code(0)), 32'h0);
        check("R5 empty pop data", 32'(rdata_o[7:0]), 32'h0);
        do_push(0, 8'hD4);
        check("R5 push after empty pop", 32'(code(0)), 32'h1);
        check("R5 data after empty pop", 32'(rdata_o[7:0]), 32'hD4);
        do_pop(0);
        check("R5 back to empty", 32'(stat_o), 32'h0);
    endtask

    task automatic t_fields();
        for (int i = 1; i < 4; i++) begin
            do_push(i, 8'(8'h10 + i));
            check("R1 field position", 32'(stat_o), 32'(1 << (2*i)));
            check("R1 byte lane", 32'(rdata_o), 32'(8'h10 + i) << (8*i));
            do_pop(i);
            check("R1 field cleared", 32'(stat_o), 32'h0);
        end
    endtask

    task automatic t_fresh_then_full();
        do_push(3, 8'h31);
        check("R2 fresh on q3", 32'(code(3)), 32'h1);
        do_push(3, 8'h32);
        check("R2 full from fresh", 32'(code(3)), 32'h3);
        do_pop(3);
        do_pop(3);
        check("R2 q3 empty", 32'(code(3)), 32'h0);
    endtask

    task automatic t_clear_stx();
        do_push(0, 8'h01);
        do_push(0, 8'h02);
        do_write(16'h0100);
        check("R6 request pending", 32'(stat_o[8]), 32'h1);
        check("R6 queue intact while pending", 32'(code(0)), 32'h3);
        push_i[0] = 1'b1;
        wdata_i[7:0] = 8'h03;
        cyc();
        push_i[0] = 1'b0;
        check("R6 request dropped", 32'(stat_o[8]), 32'h0);
        check("R9 clear beats push", 32'(code(0)), 32'h0);
        check("R9 rdata after clear", 32'(rdata_o[7:0]), 32'h0);
    endtask

    task automatic t_clear_mtx();
        do_push(2, 8'h21);
        do_push(2, 8'h22);
        do_push(1, 8'h11);
        do_push(0, 8'h05);
        cyc();
        check("R7 setup", 32'(stat_o), 32'h003A);
        do_write(16'h0200);
        check("R7 request pending", 32'(stat_o), 32'h023A);
        cyc();
        check("R7 mtx and srx cleared", 32'(stat_o), 32'h0002);
        check("R7 stx byte kept", 32'(rdata_o[7:0]), 32'h05);
    endtask

    task automatic t_reserved();
        do_write(16'hFCFF);
        check("R8 ignored bits", 32'(stat_o), 32'h0002);
        cyc();
        check("R8 no late effect", 32'(stat_o), 32'h0002);
        do_pop(0);
        check("R8 final empty", 32'(stat_o), 32'h0);
        check("R4 ovf sticky", 32'(ovf_o), 32'h1);
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_codes_order();
        t_empty_pop();
        t_fields();
        t_fresh_then_full();
        t_clear_stx();
        t_clear_mtx();
        t_reserved();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule